// File: doc/BRIEF.md
# Multichannel Streaming Test Pattern Source

This block produces known data on a streaming output so that a downstream receiver can be checked for correctness. A controller writes segment commands into a 16-entry queue through a small write port. Each command names a channel, a length in symbols, and whether the segment opens and/or closes a packet. The block emits each segment as beats on a valid/ready stream. Every beat carries channel, start-of-packet, end-of-packet, empty-lane and error sidebands.

Each channel keeps its own running symbol position, so fragments of packets on several channels can be interleaved freely. Every symbol equals its position in the packet XORed with a mask. A second command word sets the faults to inject: a data XOR mask, a value for the error sideband, and suppression of the packet start or end marker. These settings stay in force until they are overwritten. A small register bank gives enable, soft reset, identification, fill level and busy. A per-beat permission input from an external rate-limiting unit decides when a new beat may be formed.

Top module: `stream_pattern_src`

## Requirements
- R1: Lane k of a beat (bits [k*SYM_W +: SYM_W], lane 0 lowest) carries symbol position p+k, where p is the position of the beat's first symbol. The position is truncated to SYM_W bits and XORed with the 8-bit mask captured with the command.
- R2: A write to command address 0 queues one command. A write to command address 1 queues nothing. It stores the fault word: bits [15:0] error value, [23:16] data mask, [24] suppress SOP, [25] suppress EOP. This word applies to every later command until it is rewritten.
- R3: The command word at address 0 holds the size in [15:0], the channel in [29:16] (low bits used), SOP in [30] and EOP in [31]. When 16 commands are queued, a write to address 0 raises cmd_wait_o and is held off, and no command is lost. The write completes once space frees.
- R4: All beats of a segment are full except the final beat of a segment with EOP. That beat holds the remaining symbols, and st_empty_o is SYMS minus that count. A segment without EOP whose size is not a multiple of SYMS is padded to the next multiple, and the padding symbols consume positions.
- R5: Each channel keeps its own position across segments. A segment with SOP starts at position 0, and any other segment continues where that channel's previous segment stopped.
- R6: st_sop_o is high on the first beat of an SOP segment unless suppressed. st_eop_o is high on the last beat of an EOP segment unless suppressed. st_empty_o is nonzero only with st_eop_o. st_err_o carries the error value on every beat of the segment.
- R7: While control bit 0 (enable) is 0, no new beat is produced but commands are still queued. The fill register at offset 2 reports the queue count in bits [15:7].
- R8: While control bit 17 (soft reset) is 1, the queue, the per-channel positions and the output beat are cleared.
- R9: Register offset 0 reads 0x64 in [15:0], the channel count in [23:16], SYMS in [30:24] and packet support in [31].
- R10: Fill register bit 0 (busy) is 1 while a command is queued, a segment is in progress or a beat awaits acceptance, and 0 otherwise.
- R11: A new beat is formed only in a cycle where beat_ok_i is 1. Once st_valid_o is raised, the beat is held unchanged until st_ready_i accepts it.
- R12: After reset st_valid_o and cmd_wait_o are 0 and the fill register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_wr_i | input | 1 | Command port write strobe |
| cmd_addr_i | input | 1 | Command word select (0 queues, 1 fault word) |
| cmd_wdata_i | input | 32 | Command write data |
| cmd_wait_o | output | 1 | Command write held off (queue full) |
| csr_wr_i | input | 1 | Register write strobe |
| csr_addr_i | input | 2 | Register offset |
| csr_wdata_i | input | 32 | Register write data |
| csr_rdata_o | output | 32 | Register read data (combinational) |
| beat_ok_i | input | 1 | Rate gate: a beat may be formed this cycle |
| st_valid_o | output | 1 | Stream beat valid |
| st_ready_i | input | 1 | Stream beat accepted |
| st_data_o | output | SYM_W*SYMS | Beat symbols, lane 0 in low bits |
| st_chan_o | output | clog2(NUM_CH) | Channel of the beat |
| st_sop_o | output | 1 | Start of packet |
| st_eop_o | output | 1 | End of packet |
| st_empty_o | output | clog2(SYMS) | Unused lanes on the EOP beat |
| st_err_o | output | ERR_W | Error sideband |

## Verification
The pattern is driven with whole packets whose length is not a multiple of the beat width, which tests remainder and empty handling. It is also driven with packet fragments interleaved across channels, which shows whether positions are kept per channel rather than globally, and with non-final fragments of odd length, which tests padding. Fault words with each suppression bit and mask are applied across several commands to confirm that they persist and that they reach only the intended field. Random back-pressure and rate gating run under the same traffic and separate beat-holding errors from pattern errors. Disable, queue-full stall and soft-reset phases show that queuing, the stall, clearing and position restart are independent of output flow.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam logic [15:0] SRC_ID = 16'h0064;

  typedef struct packed {
    logic [15:0] size;
    logic [13:0] chan;
    logic        sop;
    logic        eop;
    logic [15:0] err;
    logic [7:0]  mask;
    logic        sup_sop;
    logic        sup_eop;
  } seg_cmd_t;

  function automatic seg_cmd_t make_cmd(input logic [31:0] lo, input logic [25:0] hi);
    seg_cmd_t c;
    c.size    = lo[15:0];
    c.chan    = lo[29:16];
    c.sop     = lo[30];
    c.eop     = lo[31];
    c.err     = hi[15:0];
    c.mask    = hi[23:16];
    c.sup_sop = hi[24];
    c.sup_eop = hi[25];
    return c;
  endfunction
endpackage

// File: rtl/sp_cmd_fifo.sv
module sp_cmd_fifo #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  sp_pkg::seg_cmd_t din_i,
  input  logic             pop_i,
  output sp_pkg::seg_cmd_t dout_o,
  output logic [CW-1:0]    count_o,
  output logic             full_o,
  output logic             empty_o
);
  sp_pkg::seg_cmd_t mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign count_o = cnt;
  assign dout_o  = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (clr_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_i) wr_ptr <= nxt(wr_ptr);
      if (pop_i)  rd_ptr <= nxt(rd_ptr);
      case ({push_i, pop_i})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o) else $error("command queue overflow");
  assert_no_underflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o) else $error("command queue underflow");
endmodule

// File: rtl/sp_pos_table.sv
module sp_pos_table #(
  parameter int NUM_CH = 4,
  parameter int POS_W  = 16,
  localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CHW-1:0]   rd_ch_i,
  output logic [POS_W-1:0] rd_pos_o,
  input  logic             wr_i,
  input  logic [CHW-1:0]   wr_ch_i,
  input  logic [POS_W-1:0] wr_pos_i
);
  logic [POS_W-1:0] pos_q [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              pos_q[c] <= '0;
      else if (clr_i)                           pos_q[c] <= '0;
      else if (wr_i && wr_ch_i == CHW'(c))      pos_q[c] <= wr_pos_i;
    end
  end

  always_comb begin
    rd_pos_o = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (rd_ch_i == CHW'(c)) rd_pos_o = pos_q[c];
  end

  assert_clear_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> rd_pos_o == '0) else $error("position not cleared");
endmodule

// File: rtl/sp_beat_engine.sv
module sp_beat_engine #(
  parameter int NUM_CH  = 4,
  parameter int SYM_W   = 8,
  parameter int SYMS    = 4,
  parameter int ERR_W   = 4,
  parameter bit PACKETS = 1'b1,
  parameter int POS_W   = 16,
  localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int EMW = (SYMS > 1) ? $clog2(SYMS) : 1,
  localparam int DW  = SYM_W * SYMS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             gate_i,
  input  sp_pkg::seg_cmd_t cmd_i,
  input  logic             cmd_avail_i,
  output logic             pop_o,
  output logic [CHW-1:0]   tab_rd_ch_o,
  input  logic [POS_W-1:0] tab_pos_i,
  output logic             tab_wr_o,
  output logic [CHW-1:0]   tab_wr_ch_o,
  output logic [POS_W-1:0] tab_pos_o,
  output logic             active_o,
  output logic             valid_o,
  input  logic             ready_i,
  output logic [DW-1:0]    data_o,
  output logic [CHW-1:0]   chan_o,
  output logic             sop_o,
  output logic             eop_o,
  output logic [EMW-1:0]   empty_o,
  output logic [ERR_W-1:0] err_o
);
  sp_pkg::seg_cmd_t seg_q;
  logic             active_q, first_q;
  logic [15:0]      rem_q;
  logic [POS_W-1:0] pos_q;

  logic             last_b, pkt_end, load;
  logic [15:0]      adv;
  logic [POS_W-1:0] pos_nx;
  logic [SYM_W-1:0] mask_s;
  logic [DW-1:0]    lanes;

  assign last_b  = (rem_q <= 16'(SYMS));
  assign pkt_end = PACKETS && seg_q.eop && last_b;
  assign adv     = pkt_end ? rem_q : 16'(SYMS);
  assign pos_nx  = pos_q + POS_W'(adv);
  assign load    = active_q && en_i && gate_i && (!valid_o || ready_i) && !clr_i;
  assign pop_o   = !active_q && cmd_avail_i && en_i && !clr_i;
  assign mask_s  = SYM_W'(seg_q.mask);

  assign tab_rd_ch_o = cmd_i.chan[CHW-1:0];
  assign tab_wr_ch_o = seg_q.chan[CHW-1:0];
  assign tab_wr_o    = load && last_b;
  assign tab_pos_o   = pos_nx;
  assign active_o    = active_q;

  for (genvar k = 0; k < SYMS; k++) begin : g_lane
    assign lanes[k*SYM_W +: SYM_W] = SYM_W'(pos_q + POS_W'(k)) ^ mask_s;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q    <= '0;
      active_q <= 1'b0;
      first_q  <= 1'b0;
      rem_q    <= '0;
      pos_q    <= '0;
    end else if (clr_i) begin
      active_q <= 1'b0;
      first_q  <= 1'b0;
      rem_q    <= '0;
      pos_q    <= '0;
    end else if (pop_o) begin
      seg_q    <= cmd_i;
      rem_q    <= cmd_i.size;
      pos_q    <= (PACKETS && cmd_i.sop) ? '0 : tab_pos_i;
      first_q  <= 1'b1;
      active_q <= (cmd_i.size != '0);
    end else if (load) begin
      rem_q   <= rem_q - (last_b ? rem_q : 16'(SYMS));
      pos_q   <= pos_nx;
      first_q <= 1'b0;
      if (last_b) active_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      chan_o  <= '0;
      sop_o   <= 1'b0;
      eop_o   <= 1'b0;
      empty_o <= '0;
      err_o   <= '0;
    end else if (clr_i) begin
      valid_o <= 1'b0;
    end else if (load) begin
      valid_o <= 1'b1;
      data_o  <= lanes;
      chan_o  <= seg_q.chan[CHW-1:0];
      sop_o   <= PACKETS && first_q && seg_q.sop && !seg_q.sup_sop;
      eop_o   <= pkt_end && !seg_q.sup_eop;
      empty_o <= (pkt_end && !seg_q.sup_eop) ? EMW'(16'(SYMS) - rem_q) : '0;
      err_o   <= seg_q.err[ERR_W-1:0];
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i && !clr_i |=> valid_o && $stable(data_o) && $stable(chan_o) && $stable(eop_o))
    else $error("beat changed while stalled");
  assert_gate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(gate_i)) else $error("beat formed without permission");
  assert_enable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(en_i)) else $error("beat formed while disabled");
  assert_empty_eop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && empty_o != '0 |-> eop_o) else $error("empty lanes outside packet end");
endmodule

// File: rtl/stream_pattern_src.sv
module stream_pattern_src #(
  parameter int NUM_CH     = 4,
  parameter int SYM_W      = 8,
  parameter int SYMS       = 4,
  parameter int ERR_W      = 4,
  parameter bit PACKETS    = 1'b1,
  parameter int FIFO_DEPTH = 16,
  localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int EMW = (SYMS > 1) ? $clog2(SYMS) : 1,
  localparam int DW  = SYM_W * SYMS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_wr_i,
  input  logic             cmd_addr_i,
  input  logic [31:0]      cmd_wdata_i,
  output logic             cmd_wait_o,
  input  logic             csr_wr_i,
  input  logic [1:0]       csr_addr_i,
  input  logic [31:0]      csr_wdata_i,
  output logic [31:0]      csr_rdata_o,
  input  logic             beat_ok_i,
  output logic             st_valid_o,
  input  logic             st_ready_i,
  output logic [DW-1:0]    st_data_o,
  output logic [CHW-1:0]   st_chan_o,
  output logic             st_sop_o,
  output logic             st_eop_o,
  output logic [EMW-1:0]   st_empty_o,
  output logic [ERR_W-1:0] st_err_o
);
  localparam int CW    = $clog2(FIFO_DEPTH + 1);
  localparam int POS_W = 16;

  logic        en_q, srst_q;
  logic [25:0] hi_q;
  logic        push, pop, full, empty, active, busy;
  logic [CW-1:0] count;
  sp_pkg::seg_cmd_t head;
  logic [CHW-1:0]   rd_ch, wr_ch;
  logic [POS_W-1:0] rd_pos, wr_pos;
  logic             tab_wr;

  assign push       = cmd_wr_i && !cmd_addr_i && !full && !srst_q;
  assign cmd_wait_o = cmd_wr_i && !cmd_addr_i && full && !srst_q;
  assign busy       = active || !empty || st_valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      srst_q <= 1'b0;
      hi_q   <= '0;
    end else begin
      if (csr_wr_i && csr_addr_i == 2'd1) begin
        en_q   <= csr_wdata_i[0];
        srst_q <= csr_wdata_i[17];
      end
      if (cmd_wr_i && cmd_addr_i) hi_q <= cmd_wdata_i[25:0];
    end
  end

  always_comb begin
    case (csr_addr_i)
      2'd0:    csr_rdata_o = {PACKETS, 7'(SYMS), 8'(NUM_CH), sp_pkg::SRC_ID};
      2'd1:    csr_rdata_o = {14'b0, srst_q, 16'b0, en_q};
      2'd2:    csr_rdata_o = {16'b0, 9'(count), 6'b0, busy};
      default: csr_rdata_o = '0;
    endcase
  end

  sp_cmd_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .clr_i(srst_q),
    .push_i(push), .din_i(sp_pkg::make_cmd(cmd_wdata_i, hi_q)),
    .pop_i(pop), .dout_o(head), .count_o(count), .full_o(full), .empty_o(empty)
  );

  sp_pos_table #(.NUM_CH(NUM_CH), .POS_W(POS_W)) u_pos (
    .clk_i, .rst_ni, .clr_i(srst_q),
    .rd_ch_i(rd_ch), .rd_pos_o(rd_pos),
    .wr_i(tab_wr), .wr_ch_i(wr_ch), .wr_pos_i(wr_pos)
  );

  sp_beat_engine #(
    .NUM_CH(NUM_CH), .SYM_W(SYM_W), .SYMS(SYMS), .ERR_W(ERR_W),
    .PACKETS(PACKETS), .POS_W(POS_W)
  ) u_eng (
    .clk_i, .rst_ni, .clr_i(srst_q), .en_i(en_q), .gate_i(beat_ok_i),
    .cmd_i(head), .cmd_avail_i(!empty), .pop_o(pop),
    .tab_rd_ch_o(rd_ch), .tab_pos_i(rd_pos), .tab_wr_o(tab_wr),
    .tab_wr_ch_o(wr_ch), .tab_pos_o(wr_pos), .active_o(active),
    .valid_o(st_valid_o), .ready_i(st_ready_i), .data_o(st_data_o),
    .chan_o(st_chan_o), .sop_o(st_sop_o), .eop_o(st_eop_o),
    .empty_o(st_empty_o), .err_o(st_err_o)
  );

  assert_wait_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wait_o |-> count == CW'(FIFO_DEPTH)) else $error("stall without full queue");
  assert_hi_no_push_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i && cmd_addr_i && !pop && !srst_q |=> count == $past(count))
    else $error("fault-word write changed queue");
  assert_srst_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_q |=> !st_valid_o && count == '0) else $error("soft reset left state");
endmodule

// File: tb/tb_stream_pattern_src.sv
`timescale 1ns/1ps
module tb_stream_pattern_src;
  localparam int NUM_CH = 4, SYM_W = 8, SYMS = 4, ERR_W = 4;
  localparam int CHW = 2, EMW = 2, DW = SYM_W * SYMS;

  typedef struct packed {
    logic [DW-1:0]    data;
    logic [CHW-1:0]   ch;
    logic             sop;
    logic             eop;
    logic [EMW-1:0]   empty;
    logic [ERR_W-1:0] err;
  } beat_t;

  logic clk_i = 0, rst_ni = 0;
  logic cmd_wr_i = 0, cmd_addr_i = 0;
  logic [31:0] cmd_wdata_i = 0;
  logic cmd_wait_o;
  logic csr_wr_i = 0;
  logic [1:0] csr_addr_i = 0;
  logic [31:0] csr_wdata_i = 0, csr_rdata_o;
  logic beat_ok_i = 1, st_valid_o, st_ready_i = 1;
  logic [DW-1:0] st_data_o;
  logic [CHW-1:0] st_chan_o;
  logic st_sop_o, st_eop_o;
  logic [EMW-1:0] st_empty_o;
  logic [ERR_W-1:0] st_err_o;

  always #4 clk_i = ~clk_i;

  stream_pattern_src dut (.*);

  int checks = 0, errors = 0, cyc = 0, valid_seen = 0;
  bit rdy_rand = 0, gate_rand = 0, gate_off = 0;
  logic [31:0] lf = 32'h1234_5678;
  logic [31:0] mhi = 0;
  int mpos [NUM_CH];
  beat_t exp_q [$];

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Reference: expand one accepted command into expected beats
  task automatic model_push(int ch, int size, bit sop, bit eop);
    int pos, rem;
    bit first, last, pend;
    beat_t b;
    pos = sop ? 0 : mpos[ch];
    rem = size;
    first = 1;
    while (rem > 0) begin
      last = (rem <= SYMS);
      pend = eop && last;
      for (int k = 0; k < SYMS; k++)
        b.data[k*SYM_W +: SYM_W] = 8'((pos + k) & 255) ^ mhi[23:16];
      b.ch    = CHW'(ch);
      b.sop   = first && sop && !mhi[24];
      b.eop   = pend && !mhi[25];
      b.empty = b.eop ? EMW'(SYMS - rem) : '0;
      b.err   = mhi[ERR_W-1:0];
      exp_q.push_back(b);
      pos   = (pos + (pend ? rem : SYMS)) & 16'hFFFF;
      rem   = rem - (last ? rem : SYMS);
      first = 0;
    end
    mpos[ch] = pos;
  endtask

  task automatic csr_write(logic [1:0] a, logic [31:0] v);
    @(negedge clk_i);
    csr_addr_i = a; csr_wdata_i = v; csr_wr_i = 1;
    @(negedge clk_i);
    csr_wr_i = 0;
  endtask

  task automatic csr_read(logic [1:0] a, output logic [31:0] v);
    @(negedge clk_i);
    csr_addr_i = a;
    #1 v = csr_rdata_o;
  endtask

  task automatic cmd_hi(logic [31:0] v);
    @(negedge clk_i);
    cmd_addr_i = 1; cmd_wdata_i = v; cmd_wr_i = 1;
    mhi = v;
    @(negedge clk_i);
    cmd_wr_i = 0;
  endtask

  task automatic push(int ch, int size, bit sop, bit eop);
    @(negedge clk_i);
    cmd_addr_i = 0; cmd_wdata_i = {eop, sop, 14'(ch), 16'(size)}; cmd_wr_i = 1;
    #1;
    while (cmd_wait_o) begin
      @(negedge clk_i);
      #1;
    end
    model_push(ch, size, sop, eop);
    @(negedge clk_i);
    cmd_wr_i = 0;
  endtask

  task automatic drain(string tag);
    logic [31:0] v;
    for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk_i);
    repeat (6) @(negedge clk_i);
    chk(tag, 32'(exp_q.size()), 0);
    csr_read(2, v);
    chk("R10 idle busy", v, 0);
  endtask

  // Per-clock monitor and stream comparison
  always begin
    beat_t g, e;
    @(negedge clk_i);
    lf = lf * 32'd1103515245 + 32'd12345;
    st_ready_i = rdy_rand ? lf[20] | lf[23] : 1'b1;
    beat_ok_i  = gate_off ? 1'b0 : (gate_rand ? lf[25] | lf[27] : 1'b1);
    #1;
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: got cycle %0d expected below 150000", cyc);
      finish_run();
    end
    if (st_valid_o) valid_seen++;
    if (st_valid_o && st_ready_i) begin
      g = {st_data_o, st_chan_o, st_sop_o, st_eop_o, st_empty_o, st_err_o};
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R7 unexpected beat: got %h expected none", g);
      end else begin
        e = exp_q.pop_front();
        if (g !== e) begin
          errors++;
          $display("FAIL R1 R4 R5 R6 beat: got %h expected %h", g, e);
        end
      end
    end
  end

  initial begin
    logic [31:0] v;
    for (int c = 0; c < NUM_CH; c++) mpos[c] = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    #1;
    chk("R12 valid", 32'(st_valid_o), 0);
    chk("R12 wait", 32'(cmd_wait_o), 0);
    csr_read(2, v);
    chk("R12 fill", v, 0);
    csr_read(0, v);
    chk("R9 status", v, 32'h8404_0064);

    csr_write(1, 1);
    push(1, 10, 1, 1);
    drain("R4 remainder packet");

    rdy_rand = 1; gate_rand = 1;
    push(0, 8, 1, 0);
    push(2, 4, 1, 0);
    push(0, 3, 0, 1);
    push(2, 5, 0, 1);
    drain("R5 interleave");

    push(3, 5, 1, 0);
    push(3, 2, 0, 1);
    drain("R4 padding");

    cmd_hi(32'h01A5_0005);
    push(1, 6, 1, 1);
    push(2, 3, 1, 1);
    cmd_hi(32'h023C_0000);
    push(2, 7, 1, 1);
    cmd_hi(0);
    push(1, 4, 1, 1);
    drain("R6 faults R1 mask R2 persist");

    csr_write(1, 0);
    cmd_hi(32'h0011_0000);
    csr_read(2, v);
    chk("R2 fault word no push", v, 0);
    cmd_hi(0);

    valid_seen = 0;
    push(0, 4, 1, 1);
    push(1, 4, 1, 1);
    push(2, 4, 1, 1);
    repeat (20) @(negedge clk_i);
    chk("R7 no beats disabled", 32'(valid_seen), 0);
    csr_read(2, v);
    chk("R7 fill count R10 busy", v, 32'h181);

    for (int i = 0; i < 13; i++) push(i % NUM_CH, 5, 1, 1);
    csr_read(2, v);
    chk("R3 full count", v, 32'h801);
    @(negedge clk_i);
    cmd_addr_i = 0; cmd_wdata_i = {1'b1, 1'b1, 14'd3, 16'd9}; cmd_wr_i = 1;
    #1;
    chk("R3 wait raised", 32'(cmd_wait_o), 1);
    @(negedge clk_i);
    csr_addr_i = 1; csr_wdata_i = 1; csr_wr_i = 1;
    @(negedge clk_i);
    csr_wr_i = 0;
    #1;
    while (cmd_wait_o) begin
      @(negedge clk_i);
      #1;
    end
    model_push(3, 9, 1, 1);
    @(negedge clk_i);
    cmd_wr_i = 0;
    drain("R3 stalled write kept");

    rdy_rand = 0; gate_rand = 0; gate_off = 1;
    valid_seen = 0;
    push(0, 4, 1, 1);
    repeat (20) @(negedge clk_i);
    chk("R11 gate closed", 32'(valid_seen), 0);
    gate_off = 0;
    drain("R11 gate reopened");

    push(3, 4, 1, 0);
    drain("R5 pre soft reset");
    csr_write(1, 0);
    push(3, 4, 0, 0);
    push(3, 4, 0, 0);
    csr_write(1, 32'h0002_0000);
    csr_read(2, v);
    chk("R8 queue cleared", v, 0);
    exp_q.delete();
    for (int c = 0; c < NUM_CH; c++) mpos[c] = 0;
    csr_write(1, 1);
    push(3, 4, 0, 0);
    drain("R8 position restart");

    finish_run();
  end
endmodule